// File: doc/BRIEF.md
# Linked Region Table Walker

This block produces the write address for every byte of a trace stream whose storage is scattered over many memory regions. The regions are described by 64-bit entries held in tables in memory. Each entry carries a few attribute bits, a 4 KiB-aligned region address and a size code. An entry can also be a link. A link redirects the walk to another table, or back to the top of the same table to form a ring. A table has no fixed length: a link may sit at any index. The regions together act as one continuous buffer, so a packet that straddles two regions needs no special handling from the producer.

Three pieces of state drive the walk: the current table address, the index of the entry in use, and the byte offset inside the current region. When tracing is switched on, these are loaded from a base input and from a packed pointer input. The block then fetches entries through a simple request/response read port. While a fetch is in flight, the byte input is held off. The copies of the state that software can read are refreshed only when tracing is switched off, so they lag the internal state while the walk runs.

Top module: `trace_region_walker`

## Requirements
- R1: After reset, `byteReady`, `memReqValid` and `wrValid` are low, and `archBase` and `archPtrs` are zero.
- R2: On a rising `enable` from idle, the table address is taken from `cfgBase`, the entry index from `cfgPtrs[31:7]` and the region offset from `cfgPtrs[63:32]`. The first fetch reads address `cfgBase + 8*index`.
- R3: An entry is a link when bit 0 is 1. Otherwise it describes a region at address `{entry[63:12], 12'h000}` with a size of 4096 << `entry[9:6]` bytes. The attribute bits `{entry[11:10], entry[5:1]}` appear on `wrAttr` with each write to that region.
- R4: Each accepted byte (`byteValid` and `byteReady` both high) asserts `wrValid` in that cycle, with `wrAddr` = region address + offset. The offset then advances by one, so consecutive writes within a region are one address apart.
- R5: When a byte fills the last location of a region, the offset returns to 0 and the index advances by one. The entry at `table + 8*(index+1)` is fetched before any further byte is accepted.
- R6: A fetched link replaces the table address with `{entry[63:12], 12'h000}`, sets the index to 0 and fetches again, with no write emitted. A link to the same table forms a ring.
- R7: `byteReady` is low whenever `memReqValid` is high, and it is low while the block is idle.
- R8: A read request holds `memReqValid` and a stable `memReqAddr` until a cycle with `memRspValid` high, which completes it.
- R9: One cycle after `enable` is low, both `byteReady` and `memReqValid` are low. At that point `archBase` holds the table address and `archPtrs` holds `{offset, index, low7}`, where `low7` is `cfgPtrs[6:0]` as captured at enable. A byte accepted in the cycle in which `enable` falls is already included in these values.
- R10: While tracing runs, `archBase` and `archPtrs` keep the values of the last disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Tracing on; a falling edge writes back the state |
| cfgBase | input | 64 | Table address loaded on enable |
| cfgPtrs | input | 64 | Packed pointers: offset [63:32], entry index [31:7], kept bits [6:0] |
| byteValid | input | 1 | A trace byte is offered |
| byteReady | output | 1 | The block can accept a byte this cycle |
| wrValid | output | 1 | Write address valid for the accepted byte |
| wrAddr | output | 64 | Physical address for the accepted byte |
| wrAttr | output | 7 | Attribute bits of the current region entry |
| memReqValid | output | 1 | Entry read request, held until answered |
| memReqAddr | output | 64 | Entry address being read |
| memRspValid | input | 1 | Read data valid; completes the request |
| memRspData | input | 64 | Entry read from memory |
| archBase | output | 64 | Software copy of the table address |
| archPtrs | output | 64 | Software copy of the packed pointers |

## Verification
The sensitive coincidence is the acceptance of a region's last byte in the same cycle in which `enable` falls. In that one cycle the wrap to offset 0 and the index increment must both reach the writeback. The bench provokes it by re-enabling two bytes before the end of a region, then dropping `enable` together with the second byte. It then expects the index one higher, the offset zero, no further fetch and no further write. A second overlap is a region fill that immediately yields a link. The bench judges this through the exact order of fetch addresses and the absence of any write between them.

// File: rtl/walker_pkg.sv
`timescale 1ns/1ps
package walker_pkg;

  localparam int ENTRY_W    = 64;
  localparam int LINK_BIT   = 0;
  localparam int CODE_LSB   = 6;
  localparam int CODE_W     = 4;
  localparam int PAGE_SHIFT = 12;
  localparam int ATTR_W     = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } walkState_t;

  typedef struct packed {
    logic loadCfg;
    logic takeLink;
    logic takeEntry;
    logic takeByte;
    logic writeBack;
  } walkStrobes_t;

  function automatic logic entryIsLink(input logic [ENTRY_W-1:0] e);
    return e[LINK_BIT];
  endfunction

  function automatic logic [CODE_W-1:0] entryCode(input logic [ENTRY_W-1:0] e);
    return e[CODE_LSB +: CODE_W];
  endfunction

  function automatic logic [ENTRY_W-1:0] entryPage(input logic [ENTRY_W-1:0] e);
    return {e[ENTRY_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  endfunction

  function automatic logic [ATTR_W-1:0] entryAttr(input logic [ENTRY_W-1:0] e);
    return {e[PAGE_SHIFT-1:CODE_LSB+CODE_W], e[CODE_LSB-1:LINK_BIT+1]};
  endfunction

endpackage

// File: rtl/walker_ctrl.sv
`timescale 1ns/1ps
module walker_ctrl
  import walker_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         byteValid,
  input  logic         memRspValid,
  input  logic         rspIsLink,
  input  logic         regionFull,
  output walkStrobes_t strb,
  output logic         memReqValid,
  output logic         byteReady
);

  walkState_t st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    strb   = '0;
    stNext = st;
    unique case (st)
      ST_IDLE: begin
        if (enable) begin
          strb.loadCfg = 1'b1;
          stNext       = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (!enable) begin
          strb.writeBack = 1'b1;
          stNext         = ST_IDLE;
        end else if (memRspValid) begin
          if (rspIsLink) begin
            strb.takeLink = 1'b1;
          end else begin
            strb.takeEntry = 1'b1;
            stNext         = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        strb.takeByte = byteValid;
        if (!enable) begin
          strb.writeBack = 1'b1;
          stNext         = ST_IDLE;
        end else if (byteValid && regionFull) begin
          stNext = ST_FETCH;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign memReqValid = (st == ST_FETCH);
  assign byteReady   = (st == ST_RUN);

endmodule

// File: rtl/walker_dpath.sv
`timescale 1ns/1ps
module walker_dpath
  import walker_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int IDX_W   = 25,
  parameter int IDX_LSB = 7,
  parameter int OFS_W   = 32,
  localparam int OFS_LSB = IDX_LSB + IDX_W,
  localparam int PTR_W   = OFS_LSB + OFS_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobes_t       strb,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [PTR_W-1:0]   cfgPtrs,
  input  logic [ENTRY_W-1:0] rspData,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [ATTR_W-1:0]  wrAttr,
  output logic               regionFull,
  output logic               rspIsLink,
  output logic [ADDR_W-1:0]  archBase,
  output logic [PTR_W-1:0]   archPtrs
);

  localparam int ENTRY_SHIFT = 3;

  logic [ADDR_W-1:0] tableBase, baseNext;
  logic [IDX_W-1:0]  entryIdx, idxNext;
  logic [OFS_W-1:0]  regOffset, offNext, offPlus, regionSize;
  logic [ADDR_W-1:0] regionPage;
  logic [CODE_W-1:0] sizeCode;
  logic [ATTR_W-1:0] regionAttr;
  logic [ADDR_W-1:0] linkPage;

  assign rspIsLink  = entryIsLink(rspData);
  assign linkPage   = ADDR_W'(entryPage(rspData));
  assign regionSize = OFS_W'(1) << (PAGE_SHIFT + int'(sizeCode));
  assign offPlus    = regOffset + OFS_W'(1);
  assign regionFull = (offPlus == regionSize);

  always_comb begin
    baseNext = tableBase;
    idxNext  = entryIdx;
    offNext  = regOffset;
    if (strb.takeByte) begin
      if (regionFull) begin
        offNext = '0;
        idxNext = entryIdx + IDX_W'(1);
      end else begin
        offNext = offPlus;
      end
    end
    if (strb.takeLink) begin
      baseNext = linkPage;
      idxNext  = '0;
    end
    if (strb.loadCfg) begin
      baseNext = cfgBase;
      idxNext  = cfgPtrs[IDX_LSB +: IDX_W];
      offNext  = cfgPtrs[OFS_LSB +: OFS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tableBase  <= '0;
      entryIdx   <= '0;
      regOffset  <= '0;
      regionPage <= '0;
      sizeCode   <= '0;
      regionAttr <= '0;
      archBase   <= '0;
    end else begin
      tableBase <= baseNext;
      entryIdx  <= idxNext;
      regOffset <= offNext;
      if (strb.takeEntry) begin
        regionPage <= ADDR_W'(entryPage(rspData));
        sizeCode   <= entryCode(rspData);
        regionAttr <= entryAttr(rspData);
      end
      if (strb.writeBack) archBase <= baseNext;
    end
  end

  // The low pointer bits are not walker state; they are carried through unchanged.
  generate
    if (IDX_LSB > 0) begin : g_keepLow
      logic [IDX_LSB-1:0] lowKeep;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          lowKeep  <= '0;
          archPtrs <= '0;
        end else begin
          if (strb.loadCfg)   lowKeep  <= cfgPtrs[IDX_LSB-1:0];
          if (strb.writeBack) archPtrs <= {offNext, idxNext, lowKeep};
        end
      end
    end else begin : g_noLow
      always_ff @(posedge clk) begin
        if (!rstN)               archPtrs <= '0;
        else if (strb.writeBack) archPtrs <= {offNext, idxNext};
      end
    end
  endgenerate

  assign reqAddr = tableBase + (ADDR_W'(entryIdx) << ENTRY_SHIFT);
  assign wrAddr  = regionPage + ADDR_W'(regOffset);
  assign wrAttr  = regionAttr;

endmodule

// File: rtl/trace_region_walker.sv
`timescale 1ns/1ps
module trace_region_walker
  import walker_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int IDX_W   = 25,
  parameter int IDX_LSB = 7,
  parameter int OFS_W   = 32,
  localparam int PTR_W  = IDX_LSB + IDX_W + OFS_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [PTR_W-1:0]   cfgPtrs,
  input  logic               byteValid,
  output logic               byteReady,
  output logic               wrValid,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [ATTR_W-1:0]  wrAttr,
  output logic               memReqValid,
  output logic [ADDR_W-1:0]  memReqAddr,
  input  logic               memRspValid,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic [ADDR_W-1:0]  archBase,
  output logic [PTR_W-1:0]   archPtrs
);

  walkStrobes_t strb;
  logic rspIsLink;
  logic regionFull;

  walker_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .byteValid  (byteValid),
    .memRspValid(memRspValid),
    .rspIsLink  (rspIsLink),
    .regionFull (regionFull),
    .strb       (strb),
    .memReqValid(memReqValid),
    .byteReady  (byteReady)
  );

  walker_dpath #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .IDX_LSB(IDX_LSB),
    .OFS_W  (OFS_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgBase   (cfgBase),
    .cfgPtrs   (cfgPtrs),
    .rspData   (memRspData),
    .reqAddr   (memReqAddr),
    .wrAddr    (wrAddr),
    .wrAttr    (wrAttr),
    .regionFull(regionFull),
    .rspIsLink (rspIsLink),
    .archBase  (archBase),
    .archPtrs  (archPtrs)
  );

  assign wrValid = strb.takeByte;

endmodule

// File: rtl/walker_chk.sv
`timescale 1ns/1ps
module walker_chk #(
  parameter int ADDR_W = 64,
  parameter int PAGE_W = 52
)(
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              byteReady,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              rspLink,
  input logic [PAGE_W-1:0] rspPage
);

  localparam int LOW_W = ADDR_W - PAGE_W;

  assert_ready_off_in_fetch_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !byteReady);

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid && enable) |=> (memReqValid && $stable(memReqAddr)));

  assert_link_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memRspValid && rspLink && enable)
      |=> (memReqValid && memReqAddr == {$past(rspPage), {LOW_W{1'b0}}}));

  assert_region_opens_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memRspValid && !rspLink && enable) |=> (byteReady && !memReqValid));

  assert_contiguous_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid ##1 wrValid) |-> (wrAddr == $past(wrAddr) + ADDR_W'(1)));

  assert_stop_after_disable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!byteReady && !memReqValid));

endmodule

bind trace_region_walker walker_chk #(
  .ADDR_W(ADDR_W),
  .PAGE_W(ADDR_W - walker_pkg::PAGE_SHIFT)
) u_walker_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .byteReady  (byteReady),
  .wrValid    (wrValid),
  .wrAddr     (wrAddr),
  .memReqValid(memReqValid),
  .memReqAddr (memReqAddr),
  .memRspValid(memRspValid),
  .rspLink    (memRspData[walker_pkg::LINK_BIT]),
  .rspPage    (memRspData[walker_pkg::ENTRY_W-1:walker_pkg::PAGE_SHIFT])
);

// File: tb/trace_region_walker_bench.sv
`timescale 1ns/1ps
module trace_region_walker_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        enable;
  logic [63:0] cfgBase;
  logic [63:0] cfgPtrs;
  logic        byteValid;
  logic        byteReady;
  logic        wrValid;
  logic [63:0] wrAddr;
  logic [6:0]  wrAttr;
  logic        memReqValid;
  logic [63:0] memReqAddr;
  logic        memRspValid;
  logic [63:0] memRspData;
  logic [63:0] archBase;
  logic [63:0] archPtrs;

  always #2 clk = ~clk;

  trace_region_walker u_trace_region_walker (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgBase(cfgBase), .cfgPtrs(cfgPtrs),
    .byteValid(byteValid), .byteReady(byteReady), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrAttr(wrAttr), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .archBase(archBase), .archPtrs(archPtrs)
  );

  typedef struct packed { logic [63:0] addr; logic [6:0] attr; } wrItem_t;

  int checks = 0;
  int errors = 0;
  wrItem_t     wrQ[$];
  logic [63:0] fetchQ[$];
  logic [63:0] mem [logic [63:0]];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory: answers a held request one cycle later; the answer completes it.
  always @(posedge clk) begin
    if (!rstN) begin
      memRspValid <= 1'b0;
      memRspData  <= '0;
    end else if (memReqValid && !memRspValid) begin
      memRspValid <= 1'b1;
      memRspData  <= mem.exists(memReqAddr) ? mem[memReqAddr] : 64'h0;
    end else begin
      memRspValid <= 1'b0;
    end
  end

  // Monitor: scoreboard for writes and fetches.
  always @(negedge clk) begin
    if (rstN) begin
      if (wrValid) begin
        if (wrQ.size() == 0) begin
          check(1'b0, "R4", "unexpected write", wrAddr, 64'h0);
        end else begin
          wrItem_t e;
          e = wrQ.pop_front();
          check(wrAddr == e.addr, "R4", "write address", wrAddr, e.addr);
          check(wrAttr == e.attr, "R3", "region attributes", 64'(wrAttr), 64'(e.attr));
        end
      end
      if (memReqValid && memRspValid) begin
        check(!byteReady, "R7", "ready during fetch", 64'(byteReady), 64'h0);
        if (fetchQ.size() == 0) begin
          check(1'b0, "R5", "unexpected fetch", memReqAddr, 64'h0);
        end else begin
          logic [63:0] f;
          f = fetchQ.pop_front();
          check(memReqAddr == f, "R5 R6", "fetch order", memReqAddr, f);
        end
      end
    end
  end

  task automatic pushRegion(input logic [63:0] page, input int startOfs,
                            input int count, input logic [6:0] attr);
    for (int i = 0; i < count; i++) begin
      wrItem_t e;
      e.addr = page + 64'(startOfs + i);
      e.attr = attr;
      wrQ.push_back(e);
    end
  endtask

  task automatic sendBytes(input int n, input bit dropWithLast);
    for (int i = 0; i < n; i++) begin
      byteValid = 1'b1;
      if (dropWithLast && i == n - 1) enable = 1'b0;
      do @(negedge clk); while (!byteReady);
      @(posedge clk); #1;
    end
    byteValid = 1'b0;
  endtask

  task automatic disableAndCheck(input logic [63:0] expBase, input logic [63:0] expPtrs);
    enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!byteReady && !memReqValid, "R9", "idle after disable",
          64'({byteReady, memReqValid}), 64'h0);
    check(archBase == expBase, "R9", "written-back base", archBase, expBase);
    check(archPtrs == expPtrs, "R9", "written-back pointers", archPtrs, expPtrs);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; byteValid = 1'b0; cfgBase = '0; cfgPtrs = '0;
    // Table A at 0x10000: 4 KiB region, 8 KiB region (attr bit 2), link to table B.
    mem[64'h10000] = 64'h0000_0000_0010_0000;
    mem[64'h10008] = 64'h0000_0000_0020_0044;
    mem[64'h10010] = 64'h0000_0000_0002_0001;
    // Table B at 0x20000: 4 KiB region with attrs in bits 11 and 1, link to itself.
    mem[64'h20000] = 64'h0000_0000_0030_0802;
    mem[64'h20008] = 64'h0000_0000_0002_0001;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!byteReady, "R1", "byteReady after reset", 64'(byteReady), 64'h0);
    check(!memReqValid, "R1", "memReqValid after reset", 64'(memReqValid), 64'h0);
    check(!wrValid, "R1", "wrValid after reset", 64'(wrValid), 64'h0);
    check(archBase == 64'h0, "R1", "archBase after reset", archBase, 64'h0);
    check(archPtrs == 64'h0, "R1", "archPtrs after reset", archPtrs, 64'h0);
    @(posedge clk); #1;
    rstN = 1'b1;

    // Phase 1 (R2 R5 R6): start 6 bytes before the end of A0, run into table B.
    fetchQ.push_back(64'h10000);
    fetchQ.push_back(64'h10008);
    fetchQ.push_back(64'h10010);
    fetchQ.push_back(64'h20000);
    pushRegion(64'h100000, 4090, 6, 7'h00);
    pushRegion(64'h200000, 0, 8192, 7'h02);
    pushRegion(64'h300000, 0, 10, 7'h41);
    cfgBase = 64'h10000;
    cfgPtrs = {32'd4090, 25'd0, 7'h15};
    enable  = 1'b1;
    sendBytes(6 + 8192 + 10, 1'b0);
    disableAndCheck(64'h20000, {32'd10, 25'd0, 7'h15});

    // Phase 2: last byte of a region coincides with disable (R5 R9), lag check (R10).
    fetchQ.push_back(64'h20000);
    pushRegion(64'h300000, 4094, 2, 7'h41);
    cfgBase = 64'h20000;
    cfgPtrs = {32'd4094, 25'd0, 7'h00};
    enable  = 1'b1;
    sendBytes(1, 1'b0);
    @(negedge clk);
    check(archBase == 64'h20000, "R10", "archBase held while running", archBase, 64'h20000);
    check(archPtrs == {32'd10, 25'd0, 7'h15}, "R10", "archPtrs held while running",
          archPtrs, {32'd10, 25'd0, 7'h15});
    @(posedge clk); #1;
    sendBytes(1, 1'b1);
    @(negedge clk);
    check(!byteReady && !memReqValid, "R9", "idle after coincident disable",
          64'({byteReady, memReqValid}), 64'h0);
    check(archBase == 64'h20000, "R9", "base after coincident disable", archBase, 64'h20000);
    check(archPtrs == {32'd0, 25'd1, 7'h00}, "R5", "wrap folded into writeback",
          archPtrs, {32'd0, 25'd1, 7'h00});
    @(posedge clk); #1;

    // Phase 3: start on a link entry at index 1 (R2 R6), wrap around the ring twice.
    fetchQ.push_back(64'h20008);
    fetchQ.push_back(64'h20000);
    fetchQ.push_back(64'h20008);
    fetchQ.push_back(64'h20000);
    pushRegion(64'h300000, 0, 4096, 7'h41);
    pushRegion(64'h300000, 0, 3, 7'h41);
    cfgBase = 64'h20000;
    cfgPtrs = {32'd0, 25'd1, 7'h00};
    enable  = 1'b1;
    sendBytes(4096 + 3, 1'b0);
    disableAndCheck(64'h20000, {32'd3, 25'd0, 7'h00});

    repeat (4) @(posedge clk);
    check(wrQ.size() == 0, "R4", "writes outstanding", 64'(wrQ.size()), 64'h0);
    check(fetchQ.size() == 0, "R6", "fetches outstanding", 64'(fetchQ.size()), 64'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule